// File: doc/BRIEF.md
# Bit-addressable internal data RAM

This block is the 256-byte working memory of an 8-bit controller core. A single request port reaches one byte array in several ways. A direct byte access uses an 8-bit address, and addresses of 80h and above go out to a special-function-register port instead of the RAM. An indirect byte access reaches the full 256 bytes. A single-bit access addresses any of the 128 flags held in bytes 20h-2Fh. A working-register access reaches R0-R7 of the bank chosen by a two-bit select. Push and pop requests run a stack whose pointer lives inside the block.

The core's decode stage drives one request per cycle: a mode code, an address or bit number, write data and a write flag. Read results come back with a one-cycle delay and a valid strobe. Forwarded special-function-register reads return the data that the register side presents during the request cycle.

Top module: `dmem_unit`

## Requirements
- R1: With mode code 0 (direct) and an address below 80h, a request writes `wr_data` to that byte when `wr_en` is 1 and reads it when `wr_en` is 0.
- R2: A direct request with address 80h-FFh raises `sfr_sel` in the same cycle, with `sfr_addr`, `sfr_wdata` and `sfr_wr` (= `wr_en`), and leaves the RAM bytes 80h-FFh unchanged. Its read result is the `sfr_rdata` value present in the request cycle.
- R3: Mode code 1 (indirect) reads and writes any of the 256 bytes, including 80h-FFh, and shares bytes 00h-7Fh with direct access.
- R4: Mode code 3 (register) with register number n = `req_addr[2:0]` reaches byte bank*8+n, where bank is `bank_sel`.
- R5: Mode code 2 (bit) with bit number k = `req_addr[6:0]` reaches bit k mod 8 of byte 20h + k/8. A read returns that bit in `rd_data[0]` with zeros above it. A write stores `wr_data[0]` there and changes no other bit of the byte.
- R6: Bytes 20h-2Fh stay reachable as whole bytes, and byte and bit views of them agree.
- R7: `sp` is 07h after reset. Mode code 4 (push) first increments `sp` and then writes `wr_data` at the new value, so the first push after reset lands at 08h.
- R8: Mode code 5 (pop) reads the byte at `sp` and then decrements `sp`. The pointer wraps modulo 256 in both directions.
- R9: `rd_valid` is 1 exactly one cycle after each read-type request (a non-write direct, indirect, bit or register request, or a pop), and `rd_data` is valid in that cycle. Write requests produce no `rd_valid`.
- R10: While `req_valid` is 0, no byte, no `sp` value and no read strobe changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | 0 direct, 1 indirect, 2 bit, 3 register, 4 push, 5 pop |
| req_addr | input | 8 | Byte address, bit number or register number |
| wr_en | input | 1 | Write request (ignored by push and pop) |
| wr_data | input | 8 | Write data (bit writes use bit 0) |
| bank_sel | input | 2 | Working-register bank |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |
| sp | output | 8 | Stack pointer |
| sfr_sel | output | 1 | Direct access forwarded to register port |
| sfr_wr | output | 1 | Forwarded write strobe |
| sfr_addr | output | 8 | Forwarded address |
| sfr_wdata | output | 8 | Forwarded write data |
| sfr_rdata | input | 8 | Register-port read data |

## Verification
The same byte locations are written through one view and read back through another: direct against indirect, register against direct, and bit against direct. This separates the address mappings, so an error in the bank arithmetic or in the bit-to-byte split shows up as a mismatch. Address 90h is used both directly and indirectly, which shows whether forwarding protects the upper RAM. Runs of pushes and pops cross 00h/FFh to expose the wrap and the order of increment and write, and bit writes into bytes that hold all zeros or all ones show whether any neighbouring bit is disturbed.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int BANK_W    = 2;
  localparam int REGN_W    = 3;
  localparam int BITPOS_W  = $clog2(DATA_W);
  localparam int BITNUM_W  = 7;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BIT_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] SP_RST   = 8'h07;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [2:0] {
    MD_DIRECT   = 3'd0,
    MD_INDIRECT = 3'd1,
    MD_BIT      = 3'd2,
    MD_REG      = 3'd3,
    MD_PUSH     = 3'd4,
    MD_POP      = 3'd5
  } mode_e;

  function automatic addr_t reg_byte(input logic [BANK_W-1:0] bank,
                                     input logic [REGN_W-1:0] n);
    return addr_t'({bank, n});
  endfunction

  function automatic addr_t bit_byte(input logic [BITNUM_W-1:0] k);
    return BIT_BASE + addr_t'(k[BITNUM_W-1:BITPOS_W]);
  endfunction

  function automatic logic [BITPOS_W-1:0] bit_pos(input logic [BITNUM_W-1:0] k);
    return k[BITPOS_W-1:0];
  endfunction

  function automatic data_t put_bit(input data_t cur, input logic [BITPOS_W-1:0] pos,
                                    input logic v);
    data_t r;
    r = cur;
    r[pos] = v;
    return r;
  endfunction
endpackage

// File: rtl/dmem_route.sv
module dmem_route
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  addr_t             req_addr,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] bank_sel,
  output addr_t             ram_addr,
  output logic              ram_we,
  output logic              bit_wr,
  output logic              bit_acc,
  output logic [BITPOS_W-1:0] bpos,
  output logic              sfr_hit,
  output logic              rd_req,
  output addr_t             sp
);
  logic push_go, pop_go, plain_acc;

  always_comb begin
    ram_addr  = req_addr;
    sfr_hit   = 1'b0;
    plain_acc = 1'b0;
    bit_acc   = 1'b0;
    push_go   = 1'b0;
    pop_go    = 1'b0;
    bpos      = bit_pos(req_addr[BITNUM_W-1:0]);
    case (req_mode)
      MD_DIRECT:   begin plain_acc = 1'b1; sfr_hit = req_addr[ADDR_W-1]; end
      MD_INDIRECT: plain_acc = 1'b1;
      MD_BIT:      begin plain_acc = 1'b1; bit_acc = 1'b1;
                         ram_addr = bit_byte(req_addr[BITNUM_W-1:0]); end
      MD_REG:      begin plain_acc = 1'b1;
                         ram_addr = reg_byte(bank_sel, req_addr[REGN_W-1:0]); end
      MD_PUSH:     begin push_go = 1'b1; ram_addr = sp + addr_t'(1); end
      MD_POP:      begin pop_go = 1'b1; ram_addr = sp; end
      default:     ;
    endcase
    sfr_hit = sfr_hit & req_valid;
    ram_we  = req_valid & ~sfr_hit & ((plain_acc & wr_en) | push_go);
    bit_wr  = req_valid & bit_acc & wr_en;
    rd_req  = req_valid & ((plain_acc & ~wr_en) | pop_go);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sp <= SP_RST;
    else if (req_valid && push_go)   sp <= sp + addr_t'(1);
    else if (req_valid && pop_go)    sp <= sp - addr_t'(1);
  end

  p_push_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MD_PUSH) |=> sp == $past(sp) + addr_t'(1));
  p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MD_POP) |=> sp == $past(sp) - addr_t'(1));
  p_idle_sp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(sp));
  p_push_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MD_PUSH) |-> (ram_we && ram_addr == sp + addr_t'(1)));
endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  cur,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  assign cur = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
  import dmem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_mode,
  input  logic [7:0]  req_addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  bank_sel,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic [7:0]  sp,
  output logic        sfr_sel,
  output logic        sfr_wr,
  output logic [7:0]  sfr_addr,
  output logic [7:0]  sfr_wdata,
  input  logic [7:0]  sfr_rdata
);
  addr_t ram_addr;
  logic  ram_we, bit_wr, bit_acc, sfr_hit, rd_req;
  logic [BITPOS_W-1:0] bpos;
  data_t ram_cur, ram_q, ram_wdata;

  logic                sfr_q, bit_q;
  logic [BITPOS_W-1:0] bpos_q;
  data_t               sfr_data_q;

  dmem_route u_route (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .wr_en(wr_en), .bank_sel(bank_sel),
    .ram_addr(ram_addr), .ram_we(ram_we), .bit_wr(bit_wr), .bit_acc(bit_acc),
    .bpos(bpos), .sfr_hit(sfr_hit), .rd_req(rd_req), .sp(sp)
  );

  assign ram_wdata = bit_wr ? put_bit(ram_cur, bpos, wr_data[0]) : wr_data;

  dmem_array #(.DEPTH(DEPTH), .W(DATA_W)) u_array (
    .clk(clk), .we(ram_we), .re(rd_req & ~sfr_hit), .addr(ram_addr),
    .wdata(ram_wdata), .cur(ram_cur), .q(ram_q)
  );

  assign sfr_sel   = sfr_hit;
  assign sfr_wr    = sfr_hit & wr_en;
  assign sfr_addr  = req_addr;
  assign sfr_wdata = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      sfr_q      <= 1'b0;
      bit_q      <= 1'b0;
      bpos_q     <= '0;
      sfr_data_q <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        sfr_q      <= sfr_hit;
        bit_q      <= bit_acc;
        bpos_q     <= bpos;
        sfr_data_q <= sfr_rdata;
      end
    end
  end

  always_comb begin
    if (sfr_q)      rd_data = sfr_data_q;
    else if (bit_q) rd_data = data_t'(ram_q[bpos_q]);
    else            rd_data = ram_q;
  end

  p_sfr_no_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> !ram_we);
  p_bit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |-> $countones(ram_wdata ^ ram_cur) <= 1);
  p_rd_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!ram_we && !sfr_sel));
endmodule

// File: tb/dmem_unit_tb.sv
module dmem_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic [7:0] req_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] bank_sel = '0;
  logic [7:0] rd_data, sp, sfr_addr, sfr_wdata, sfr_rdata;
  logic       rd_valid, sfr_sel, sfr_wr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model [256];
  logic [7:0] sp_m;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  assign sfr_rdata = ~sfr_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .wr_en(wr_en), .wr_data(wr_data), .bank_sel(bank_sel),
    .rd_data(rd_data), .rd_valid(rd_valid), .sp(sp), .sfr_sel(sfr_sel),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every read strobe consumes one scoreboard item.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 actual=unexpected rd_valid data=%h expected=no strobe", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  // Driver: applies one request on a falling edge and predicts its result.
  task automatic op(input logic [2:0] m, input logic [7:0] a, input logic we,
                    input logic [7:0] d, input logic [1:0] b, input string tag);
    int idx;
    int pos;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_addr = a; wr_en = we; wr_data = d; bank_sel = b;
    case (m)
      3'd0: if (a >= 8'h80) begin
              if (!we) begin exp_q.push_back(~a); tag_q.push_back(tag); end
            end else if (we) model[a] = d;
            else begin exp_q.push_back(model[a]); tag_q.push_back(tag); end
      3'd1: if (we) model[a] = d;
            else begin exp_q.push_back(model[a]); tag_q.push_back(tag); end
      3'd2: begin
              idx = 32 + (a % 128) / 8;
              pos = (a % 128) % 8;
              if (we) model[idx][pos] = d[0];
              else begin exp_q.push_back({7'b0, model[idx][pos]}); tag_q.push_back(tag); end
            end
      3'd3: begin
              idx = b * 8 + (a % 8);
              if (we) model[idx] = d;
              else begin exp_q.push_back(model[idx]); tag_q.push_back(tag); end
            end
      3'd4: begin sp_m = sp_m + 8'd1; model[sp_m] = d; end
      3'd5: begin exp_q.push_back(model[sp_m]); tag_q.push_back(tag); sp_m = sp_m - 8'd1; end
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; wr_en = 1'b0;
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    sp_m = 8'h07;
    repeat (3) @(negedge clk);
    // Reset state (R7, R9)
    check("R7 reset sp", sp, 8'h07);
    check("R9 reset rd_valid", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    idle(1);

    // R1 direct lower half
    op(3'd0, 8'h30, 1, 8'hA5, 0, "R1");
    op(3'd0, 8'h45, 1, 8'h3C, 0, "R1");
    op(3'd0, 8'h30, 0, 8'h00, 0, "R1 read 30h");
    op(3'd0, 8'h45, 0, 8'h00, 0, "R1 read 45h");
    // R3 indirect, upper half and shared lower half
    op(3'd1, 8'h90, 1, 8'h77, 0, "R3");
    op(3'd1, 8'h90, 0, 8'h00, 0, "R3 read 90h");
    op(3'd1, 8'h30, 0, 8'h00, 0, "R3 read shared 30h");
    idle(2);

    // R2 forwarding of direct upper addresses
    op(3'd0, 8'h90, 1, 8'h11, 0, "R2");
    #1;
    check("R2 sfr_sel", {7'b0, sfr_sel}, 8'h01);
    check("R2 sfr_wr", {7'b0, sfr_wr}, 8'h01);
    check("R2 sfr_addr", sfr_addr, 8'h90);
    check("R2 sfr_wdata", sfr_wdata, 8'h11);
    op(3'd0, 8'h90, 0, 8'h00, 0, "R2 forwarded read");
    op(3'd1, 8'h90, 0, 8'h00, 0, "R2 upper RAM untouched");
    #1;
    check("R2 no sfr_sel on indirect", {7'b0, sfr_sel}, 8'h00);

    // R4 register banks
    op(3'd3, 8'h05, 1, 8'h5A, 2'd2, "R4");
    op(3'd3, 8'h05, 1, 8'h01, 2'd0, "R4");
    op(3'd0, 8'h15, 0, 8'h00, 0, "R4 bank2 R5 at 15h");
    op(3'd0, 8'h05, 0, 8'h00, 0, "R4 bank0 R5 at 05h");
    op(3'd3, 8'h05, 0, 8'h00, 2'd2, "R4 read bank2 R5");

    // R5/R6 bit access
    op(3'd0, 8'h24, 1, 8'h00, 0, "R6");
    op(3'd2, 8'h23, 1, 8'h01, 0, "R5");
    op(3'd0, 8'h24, 0, 8'h00, 0, "R6 byte view of bit 23h");
    op(3'd2, 8'h23, 0, 8'h00, 0, "R5 read bit 23h");
    op(3'd2, 8'h22, 0, 8'h00, 0, "R5 read bit 22h");
    op(3'd0, 8'h2F, 1, 8'hFF, 0, "R6");
    op(3'd2, 8'h7F, 1, 8'h00, 0, "R5");
    op(3'd0, 8'h2F, 0, 8'h00, 0, "R5 clear top bit only");
    op(3'd0, 8'h20, 1, 8'h80, 0, "R6");
    op(3'd2, 8'h00, 1, 8'h01, 0, "R5");
    op(3'd1, 8'h20, 0, 8'h00, 0, "R5 set bit 0 only");

    // R7 push after reset
    op(3'd4, 8'h00, 0, 8'hC3, 0, "R7");
    op(3'd0, 8'h08, 0, 8'h00, 0, "R7 first push at 08h");
    @(posedge clk); #1;
    check("R7 sp after push", sp, 8'h08);
    op(3'd4, 8'h00, 0, 8'h44, 0, "R7");
    @(posedge clk); #1;
    check("R7 sp after second push", sp, 8'h09);

    // R8 pops and wrap
    op(3'd5, 8'h00, 0, 8'h00, 0, "R8 pop 09h");
    op(3'd5, 8'h00, 0, 8'h00, 0, "R8 pop 08h");
    for (int r = 0; r < 8; r++) op(3'd3, 8'(r), 1, 8'(8'hB0 + r), 2'd0, "R8");
    op(3'd1, 8'hFF, 1, 8'hEE, 0, "R8");
    for (int r = 0; r < 8; r++) op(3'd5, 8'h00, 0, 8'h00, 0, "R8 pop bank0");
    @(posedge clk); #1;
    check("R8 sp wrap below zero", sp, 8'hFF);
    op(3'd5, 8'h00, 0, 8'h00, 0, "R8 pop FFh");
    op(3'd4, 8'h00, 0, 8'h99, 0, "R8");
    op(3'd4, 8'h00, 0, 8'h66, 0, "R8");
    @(posedge clk); #1;
    check("R8 sp wrap above FFh", sp, 8'h00);
    op(3'd1, 8'hFF, 0, 8'h00, 0, "R8 push into FFh");
    op(3'd1, 8'h00, 0, 8'h00, 0, "R8 push into 00h");
    idle(2);

    // R9 writes give no strobe
    op(3'd0, 8'h31, 1, 8'h12, 0, "R9");
    idle(1);
    #1;
    check("R9 no strobe after write", {7'b0, rd_valid}, 8'h00);

    // R10 request ignored while req_valid is low
    @(negedge clk);
    req_valid = 1'b0; req_mode = 3'd0; req_addr = 8'h30; wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    req_mode = 3'd4; wr_data = 8'h55;
    @(posedge clk); #1;
    check("R10 sp unchanged", sp, 8'h00);
    check("R10 no strobe", {7'b0, rd_valid}, 8'h00);
    op(3'd0, 8'h30, 0, 8'h00, 0, "R10 byte 30h kept");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 actual=%0d pending expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule